// File: doc/BRIEF.md
# Zero-Page Indirect Stack Engine

This block carries out stack pushes and pulls for a small 8-bit processor whose stack pointer is not kept in a register. A command supplies an 8-bit selector that names a location in zero page, the first 256 bytes of memory. The real 16-bit stack pointer is stored in memory at that location. Every command therefore runs its own read-modify-write on the pointer: the two pointer bytes are fetched, the pointer is stepped, the payload bytes are moved, and the new pointer is stored back.

The engine drives a single-port synchronous byte memory with one access per clock. Read data returns in the cycle after the request. Five commands are supported: push one byte, pull one byte, push two bytes, pull two bytes, and push a 16-bit value formed by adding a signed offset to the program counter. A one-cycle `done` pulse marks the end of each command. Commands that arrive while the engine is busy are dropped. Instruction decode and the arithmetic unit belong to the surrounding processor.

Top module: `zp_stack_engine`

## Requirements
- R1: While reset is held and after it is released with no command, `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: The stored pointer is little-endian: the low byte is at address 0x00SS and the high byte at 0x00(SS+1), where SS is `zp_sel`. SS+1 wraps inside zero page, so 0xFF is followed by 0x00.
- R3: Each command follows this order: read pointer low, read pointer high, one adjust cycle, payload transfer, write pointer low, write pointer high. `done` is high for exactly one cycle, in the cycle after the high pointer byte is written. Counting from the accepting clock edge, `done` is seen 7 cycles later for 1-byte commands and 8 cycles later for 2-byte commands.
- R4: Push byte (`cmd_op` = 0) writes `wr_data[7:0]` at pointer P and stores P-1.
- R5: Pull byte (`cmd_op` = 1) stores P+1 and returns the byte at P+1 in `rd_data[7:0]`, with `rd_data[15:8]` = 0.
- R6: Push word (`cmd_op` = 2) writes `wr_data[15:8]` at P, then `wr_data[7:0]` at P-1, and stores P-2.
- R7: Pull word (`cmd_op` = 3) reads the low result byte from P+1 and the high byte from P+2, and stores P+2. This restores a value that push word saved.
- R8: Relative push (`cmd_op` = 4) pushes `pc + pc_offset` as push word does, with the offset taken as a two's-complement 16-bit number.
- R9: Pointer stepping and the relative sum wrap modulo 65536, and no flag is raised.
- R10: A `cmd_valid` seen while `busy` is high has no effect, and `cmd_op` codes 5 to 7 are never accepted.
- R11: `mem_we` and `mem_re` are never high in the same cycle, and every pointer access addresses zero page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Command code |
| zp_sel | input | 8 | Zero-page location of the stack pointer |
| wr_data | input | 16 | Payload for push commands |
| pc | input | 16 | Program counter for relative push |
| pc_offset | input | 16 | Signed offset for relative push |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Pulled value, valid with done |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_re |

## Verification
The bench uses the default 16-bit pointer and 8-bit selector widths, with a full 64 KiB memory model. It runs a push word and a matching pull word at every one of the 256 zero-page selectors. This covers the selector 0xFF, where the pointer high byte wraps to 0x00. Pointer values at 0x0000 and 0xFFFF exercise the 16-bit wrap in both directions, and relative pushes with negative and overflowing offsets exercise the wrap of the sum.

// File: rtl/zp_stk_pkg.sv
package zp_stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH1  = 3'd0,
    OP_PULL1  = 3'd1,
    OP_PUSH2  = 3'd2,
    OP_PULL2  = 3'd3,
    OP_PUSHPC = 3'd4
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FLO  = 3'd1,
    ST_FHI  = 3'd2,
    ST_CAP  = 3'd3,
    ST_XFER = 3'd4,
    ST_WLO  = 3'd5,
    ST_WHI  = 3'd6
  } stk_st_e;
endpackage

// File: rtl/zp_stk_seq.sv
module zp_stk_seq
  import zp_stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output stk_st_e    state,
  output logic       accept,
  output logic       is_push,
  output logic       wide,
  output logic       cnt,
  output logic       done
);
  stk_st_e    state_q, state_d;
  logic [2:0] op_q, op_d;
  logic       cnt_q, cnt_d;
  logic       done_q, done_d;

  assign accept  = (state_q == ST_IDLE) && cmd_valid && (cmd_op <= OP_PUSHPC);
  assign is_push = ~op_q[0];
  assign wide    = op_q[2] | op_q[1];

  always_comb begin
    state_d = state_q;
    op_d    = accept ? cmd_op : op_q;
    cnt_d   = cnt_q;
    done_d  = (state_q == ST_WHI);
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_FLO;
      ST_FLO:  state_d = ST_FHI;
      ST_FHI:  state_d = ST_CAP;
      ST_CAP: begin
        state_d = ST_XFER;
        cnt_d   = wide;
      end
      ST_XFER: begin
        if (cnt_q) cnt_d = 1'b0;
        else       state_d = ST_WLO;
      end
      ST_WLO:  state_d = ST_WHI;
      ST_WHI:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 3'd0;
      cnt_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign cnt   = cnt_q;
  assign done  = done_q;
endmodule

// File: rtl/zp_stk_dp.sv
module zp_stk_dp
  import zp_stk_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_st_e          state,
  input  logic             accept,
  input  logic             rel_sel,
  input  logic             is_push,
  input  logic             wide,
  input  logic             cnt,
  input  logic [SEL_W-1:0] zp_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [PTR_W-1:0] pc,
  input  logic [PTR_W-1:0] pc_offset,
  input  logic [7:0]       mem_rdata,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_we,
  output logic             mem_re,
  output logic [7:0]       mem_wdata,
  output logic [PTR_W-1:0] rd_data
);
  localparam int HI_W = PTR_W - 8;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [PTR_W-1:0] val_q, val_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] res_q, res_d;
  logic             rdp_q, rdp_d;
  logic             rdi_q, rdi_d;
  logic [SEL_W-1:0] sel_hi;
  logic [PTR_W-1:0] ptr_up;

  assign sel_hi = sel_q + SEL_W'(1);
  assign ptr_up = ptr_q + PTR_W'(1);

  always_comb begin
    sel_d     = accept ? zp_sel : sel_q;
    val_d     = val_q;
    ptr_d     = ptr_q;
    res_d     = res_q;
    rdp_d     = 1'b0;
    rdi_d     = rdi_q;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = 8'h00;
    if (accept) begin
      val_d = rel_sel ? (pc + pc_offset) : wr_data;
      res_d = '0;
    end
    if (rdp_q) begin
      if (rdi_q) res_d[15:8] = mem_rdata;
      else       res_d[7:0]  = mem_rdata;
    end
    case (state)
      ST_FLO: begin
        mem_re   = 1'b1;
        mem_addr = PTR_W'(sel_q);
      end
      ST_FHI: begin
        mem_re          = 1'b1;
        mem_addr        = PTR_W'(sel_hi);
        ptr_d[7:0]      = mem_rdata;
      end
      ST_CAP: ptr_d[PTR_W-1:8] = HI_W'(mem_rdata);
      ST_XFER: begin
        if (is_push) begin
          mem_we    = 1'b1;
          mem_addr  = ptr_q;
          mem_wdata = cnt ? val_q[15:8] : val_q[7:0];
          ptr_d     = ptr_q - PTR_W'(1);
        end else begin
          mem_re   = 1'b1;
          mem_addr = ptr_up;
          ptr_d    = ptr_up;
          rdp_d    = 1'b1;
          rdi_d    = wide & ~cnt;
        end
      end
      ST_WLO: begin
        mem_we    = 1'b1;
        mem_addr  = PTR_W'(sel_q);
        mem_wdata = ptr_q[7:0];
      end
      ST_WHI: begin
        mem_we    = 1'b1;
        mem_addr  = PTR_W'(sel_hi);
        mem_wdata = 8'(ptr_q[PTR_W-1:8]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      val_q <= '0;
      ptr_q <= '0;
      res_q <= '0;
      rdp_q <= 1'b0;
      rdi_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      val_q <= val_d;
      ptr_q <= ptr_d;
      res_q <= res_d;
      rdp_q <= rdp_d;
      rdi_q <= rdi_d;
    end
  end

  assign rd_data = res_q;
endmodule

// File: rtl/zp_stack_engine.sv
module zp_stack_engine
  import zp_stk_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [SEL_W-1:0] zp_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic [PTR_W-1:0] pc,
  input  logic [PTR_W-1:0] pc_offset,
  output logic             busy,
  output logic             done,
  output logic [PTR_W-1:0] rd_data,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_we,
  output logic             mem_re,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  stk_st_e state;
  logic    accept, is_push, wide, cnt;

  zp_stk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .state     (state),
    .accept    (accept),
    .is_push   (is_push),
    .wide      (wide),
    .cnt       (cnt),
    .done      (done)
  );

  zp_stk_dp #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (accept),
    .rel_sel   (cmd_op == OP_PUSHPC),
    .is_push   (is_push),
    .wide      (wide),
    .cnt       (cnt),
    .zp_sel    (zp_sel),
    .wr_data   (wr_data),
    .pc        (pc),
    .pc_offset (pc_offset),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .rd_data   (rd_data)
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/zp_stk_chk.sv
module zp_stk_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic             mem_re,
  input logic [PTR_W-1:0] mem_addr
);
  // R11
  excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(mem_we) && ($past(mem_addr[PTR_W-1:8]) == '0));

  // R2
  fetch_zp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_re && (mem_addr[PTR_W-1:8] == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> !busy);
endmodule

bind zp_stack_engine zp_stk_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr)
);

// File: tb/tb_zp_stack_engine.sv
`timescale 1ns/1ps
module tb_zp_stack_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  zp_sel = 8'd0;
  logic [15:0] wr_data = 16'd0, pc = 16'd0, pc_offset = 16'd0;
  logic        busy, done, mem_we, mem_re;
  logic [15:0] rd_data, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;
  logic [7:0]  mem [0:65535];
  int          n_run = 0, n_fail = 0;
  int          wb_cnt = 0;

  always #4 clk = ~clk;

  zp_stack_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .zp_sel(zp_sel), .wr_data(wr_data), .pc(pc), .pc_offset(pc_offset),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wb_cnt <= wb_cnt + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [7:0] s, input logic [15:0] p);
    mem[{8'h00, s}] = p[7:0];
    mem[{8'h00, s + 8'd1}] = p[15:8];
  endtask

  function automatic logic [15:0] get_ptr(input logic [7:0] s);
    return {mem[{8'h00, s + 8'd1}], mem[{8'h00, s}]};
  endfunction

  task automatic run(input logic [2:0] op, input logic [7:0] s, input logic [15:0] d,
                     input logic [15:0] p, input logic [15:0] o, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; zp_sel = s; wr_data = d; pc = p; pc_offset = o;
    cyc = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    chk("R3 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int cyc;
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] p, v;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", {28'd0, busy, done, mem_we, mem_re}, 0);

    // R2 R6 R7: word push/pull at every selector
    for (int s = 0; s < 256; s++) begin
      p = {1'b1, s[6:0] ^ 7'h2B, s[7:0]};
      v = 16'(s * 257) ^ 16'h1234;
      set_ptr(8'(s), p);
      run(3'd2, 8'(s), v, 16'd0, 16'd0, cyc);
      chk("R3 push word cycles", cyc, 8);
      chk("R6 high byte at P", {24'd0, mem[p]}, {24'd0, v[15:8]});
      chk("R6 low byte at P-1", {24'd0, mem[p - 16'd1]}, {24'd0, v[7:0]});
      chk("R2 R6 stored pointer", {16'd0, get_ptr(8'(s))}, {16'd0, p - 16'd2});
      run(3'd3, 8'(s), 16'd0, 16'd0, 16'd0, cyc);
      chk("R7 pull word value", {16'd0, rd_data}, {16'd0, v});
      chk("R7 stored pointer", {16'd0, get_ptr(8'(s))}, {16'd0, p});
    end

    // R4 R9: push byte from 0x0000 wraps to 0xFFFF
    set_ptr(8'h40, 16'h0000);
    run(3'd0, 8'h40, 16'hBEA5, 16'd0, 16'd0, cyc);
    chk("R3 push byte cycles", cyc, 7);
    chk("R4 byte at P", {24'd0, mem[16'h0000]}, 32'hA5);
    chk("R9 pointer wraps down", {16'd0, get_ptr(8'h40)}, 32'hFFFF);
    // R5 R9: pull byte from 0xFFFF wraps to 0x0000
    run(3'd1, 8'h40, 16'd0, 16'd0, 16'd0, cyc);
    chk("R3 pull byte cycles", cyc, 7);
    chk("R5 pulled byte", {16'd0, rd_data}, 32'h00A5);
    chk("R9 pointer wraps up", {16'd0, get_ptr(8'h40)}, 32'h0000);

    // R8: negative offset
    set_ptr(8'h10, 16'h3000);
    run(3'd4, 8'h10, 16'hFFFF, 16'h1000, 16'hFFF0, cyc);
    chk("R3 relative push cycles", cyc, 8);
    chk("R8 pushed high", {24'd0, mem[16'h3000]}, 32'h0F);
    chk("R8 pushed low", {24'd0, mem[16'h2FFF]}, 32'hF0);
    run(3'd3, 8'h10, 16'd0, 16'd0, 16'd0, cyc);
    chk("R8 pull back", {16'd0, rd_data}, 32'h0FF0);
    // R9: relative sum wraps
    run(3'd4, 8'h10, 16'd0, 16'hFFF0, 16'h0020, cyc);
    run(3'd3, 8'h10, 16'd0, 16'd0, 16'd0, cyc);
    chk("R9 sum wraps", {16'd0, rd_data}, 32'h0010);

    // R10: commands while busy are dropped
    set_ptr(8'h20, 16'h5000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; zp_sel = 8'h20; wr_data = 16'h0011;
    @(negedge clk);
    cmd_op = 3'd1; wr_data = 16'h0022;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 busy command dropped ptr", {16'd0, get_ptr(8'h20)}, 32'h4FFF);
    chk("R10 busy command dropped data", {24'd0, mem[16'h5000]}, 32'h11);

    // R10: undefined codes ignored
    for (int c = 5; c < 8; c++) begin
      wb_cnt = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(c); zp_sel = 8'h20;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 bad code not busy", {31'd0, busy}, 0);
      repeat (10) @(negedge clk);
      chk("R10 bad code no writes", wb_cnt, 0);
      chk("R11 idle strobes low", {30'd0, mem_we, mem_re}, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule